// File: doc/BRIEF.md
# Microcontroller Reset Source Controller

This block merges the reset sources of a small 8-bit microcontroller into one active-high internal reset (`sys_rst`) and a latched two-bit cause code (`rst_cause`). There are four sources:

- **Power-on hold.** While the oscillator is not yet running, the block stays in reset. Once the oscillator-active flag rises, reset is held for a fixed stabilization count.
- **External pin.** An active-low external reset pin is qualified by sampling it on both clock edges, so that short glitches are rejected.
- **Watchdog.** A counter expires unless software services it with a write to one fixed bus address.
- **Illegal fetch.** An address checker flags any opcode fetch that falls outside the program-memory window and the RAM window.

The oscillator-active flag `osc_ok` acts as the block's synchronous reset. While it is low, everything returns to its power-up state. The pin must already be synchronized to `clk` before it reaches the block. The block sits between the CPU bus and the reset tree of the core.

A CPU read of the watchdog control address must return nonvolatile memory contents, not the watchdog state. For this reason the block forwards a memory data word from its input `nv_rdata` to its output `ctl_rdata`.

Top module: `mcu_reset_hub`

## Requirements
- R1: While `osc_ok` is low, `sys_rst` is 1 and `rst_cause` is 0 (power). After `osc_ok` rises, `sys_rst` stays 1 for exactly POR_CYCLES (default 4064) clock cycles and then falls, provided no other source is active.
- R2: If the pin is still low when the power-on count ends, `sys_rst` stays 1 until the pin returns high, then falls within MIN_PULSE+2 cycles, and `rst_cause` remains 0.
- R3: The pin is sampled on both clock edges. A low level seen in fewer than PIN_SAMPLES (3) consecutive samples is ignored. A one-cycle low pulse is therefore rejected and a two-cycle low pulse is accepted. An accepted low level asserts `sys_rst` with `rst_cause` 1 and holds it while the pin stays low.
- R4: The watchdog counter is held at zero while `sys_rst` is 1. If it is not serviced, `sys_rst` rises exactly WDOG_CYCLES cycles after reset is released, with `rst_cause` 2.
- R5: A write to address 0x0FF0 with data bit 0 equal to 0 restarts the watchdog period at that cycle. A write with bit 0 equal to 1, or a write of 0 to any other address, has no effect on the watchdog.
- R6: `ctl_rdata` always equals `nv_rdata`.
- R7: An opcode fetch (`bus_fetch`=1) is legal only at addresses 0x0090–0x00FF and 0x0700–0x0EFF (inclusive). A fetch at any other address while out of reset raises `sys_rst` at the next clock edge with `rst_cause` 3. A fetch inside either window causes no reset.
- R8: A bus access with `bus_fetch`=0 never causes an address reset, whatever its address.
- R9: Every reset raised by the pin, the watchdog or the address checker keeps `sys_rst` at 1 for at least MIN_PULSE (default 4) cycles. A single-cycle watchdog event gives exactly MIN_PULSE cycles.
- R10: During one reset episode, `rst_cause` only moves toward higher priority, in the order power 0, pin 1, watchdog 2, address 3. A new episode starts from the source that opened it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| osc_ok | input | 1 | Oscillator running; low acts as synchronous reset |
| pin_n | input | 1 | Synchronized external reset pin, active low |
| bus_addr | input | AW (12) | CPU bus address |
| bus_wr | input | 1 | CPU write strobe |
| bus_wdata | input | DW (8) | CPU write data |
| bus_fetch | input | 1 | Opcode-fetch strobe |
| nv_rdata | input | DW (8) | Nonvolatile memory word for the control-address read |
| sys_rst | output | 1 | Internal reset, active high, registered |
| rst_cause | output | 2 | Latched reset cause: 0 power, 1 pin, 2 watchdog, 3 address |
| ctl_rdata | output | DW (8) | Read data for the control address (copy of `nv_rdata`) |

## Verification
The assertions check the following on every cycle:
- the power-on count forces reset with the power cause;
- a qualified pin level and an illegal fetch each force reset at the next edge;
- the watchdog counter stays at zero through reset and after a service write;
- a reset never lasts a single cycle;
- the cause never drops in priority during an episode.

Only the bench's scenarios can show the rest:
- the exact power-on length;
- the one-cycle-rejected versus two-cycle-accepted pin boundary;
- the exact expiry cycle with and without service;
- that writes with bit 0 set or to a neighbouring address are ignored;
- the legal/illegal split across a sweep of fetch addresses.

// File: rtl/rsthub_pkg.sv
package rsthub_pkg;

  typedef enum logic [1:0] {
    CAUSE_POWER = 2'd0,
    CAUSE_PIN   = 2'd1,
    CAUSE_WDOG  = 2'd2,
    CAUSE_ADDR  = 2'd3
  } cause_e;

  // Highest-priority active source; lower code wins.
  function automatic cause_e pick_cause(input logic por, input logic pin,
                                        input logic wdg, input logic adr);
    cause_e c;
    if (por)      c = CAUSE_POWER;
    else if (pin) c = CAUSE_PIN;
    else if (wdg) c = CAUSE_WDOG;
    else          c = CAUSE_ADDR;
    return c;
  endfunction

endpackage

// File: rtl/rsthub_por.sv
module rsthub_por #(
  parameter int POR_CYCLES = 4064
) (
  input  logic clk,
  input  logic osc_ok,
  output logic por_busy
);
  localparam int CW = $clog2(POR_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(POR_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!osc_ok)            cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign por_busy = (cnt_q != LAST);
endmodule

// File: rtl/rsthub_pin_qual.sv
module rsthub_pin_qual #(
  parameter int PIN_SAMPLES = 3
) (
  input  logic clk,
  input  logic osc_ok,
  input  logic pin_n,
  output logic pin_low
);
  localparam int RW = $clog2(PIN_SAMPLES + 1);
  localparam logic [RW-1:0] SAT = RW'(PIN_SAMPLES);

  logic          neg_q;   // sample taken half a cycle before each rising edge
  logic [RW-1:0] run_q;   // consecutive low samples, saturating
  logic [RW-1:0] run_mid;
  logic [RW-1:0] run_nxt;

  always_ff @(negedge clk) begin
    if (!osc_ok) neg_q <= 1'b1;
    else         neg_q <= pin_n;
  end

  always_comb begin
    if (neg_q)             run_mid = '0;
    else if (run_q == SAT) run_mid = SAT;
    else                   run_mid = run_q + 1'b1;

    if (pin_n)               run_nxt = '0;
    else if (run_mid == SAT) run_nxt = SAT;
    else                     run_nxt = run_mid + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!osc_ok) run_q <= '0;
    else         run_q <= run_nxt;
  end

  assign pin_low = (run_q == SAT);
endmodule

// File: rtl/rsthub_wdog.sv
module rsthub_wdog #(
  parameter int          WDOG_CYCLES = 32768,
  parameter int          AW          = 12,
  parameter logic [11:0] WDOG_ADDR   = 12'hFF0
) (
  input  logic                            clk,
  input  logic                            osc_ok,
  input  logic                            in_rst,
  input  logic [AW-1:0]                   bus_addr,
  input  logic                            bus_wr,
  input  logic                            bus_wbit0,
  output logic                            wd_hit,
  output logic                            wd_clear,
  output logic [$clog2(WDOG_CYCLES)-1:0]  wd_count
);
  localparam int CW = $clog2(WDOG_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(WDOG_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign wd_clear = !in_rst && bus_wr && (bus_addr == AW'(WDOG_ADDR)) && !bus_wbit0;
  assign wd_hit   = !in_rst && !wd_clear && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!osc_ok || in_rst || wd_clear || wd_hit) cnt_q <= '0;
    else                                          cnt_q <= cnt_q + 1'b1;
  end

  assign wd_count = cnt_q;
endmodule

// File: rtl/rsthub_addr_chk.sv
module rsthub_addr_chk #(
  parameter int                     AW      = 12,
  parameter int                     NUM_WIN = 2,
  parameter logic [NUM_WIN*AW-1:0]  WIN_LO  = {12'h700, 12'h090},
  parameter logic [NUM_WIN*AW-1:0]  WIN_HI  = {12'hEFF, 12'h0FF}
) (
  input  logic          en,
  input  logic          bus_fetch,
  input  logic [AW-1:0] bus_addr,
  output logic          ill_hit
);
  logic [NUM_WIN-1:0] in_win;

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    assign in_win[i] = (bus_addr >= WIN_LO[i*AW +: AW]) &&
                       (bus_addr <= WIN_HI[i*AW +: AW]);
  end

  assign ill_hit = en && bus_fetch && (in_win == '0);
endmodule

// File: rtl/mcu_reset_hub.sv
module mcu_reset_hub
  import rsthub_pkg::*;
#(
  parameter int                    POR_CYCLES  = 4064,
  parameter int                    WDOG_CYCLES = 32768,
  parameter int                    MIN_PULSE   = 4,
  parameter int                    PIN_SAMPLES = 3,
  parameter int                    AW          = 12,
  parameter int                    DW          = 8,
  parameter logic [11:0]           WDOG_ADDR   = 12'hFF0,
  parameter int                    NUM_WIN     = 2,
  parameter logic [NUM_WIN*AW-1:0] WIN_LO      = {12'h700, 12'h090},
  parameter logic [NUM_WIN*AW-1:0] WIN_HI      = {12'hEFF, 12'h0FF}
) (
  input  logic          clk,
  input  logic          osc_ok,
  input  logic          pin_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_fetch,
  input  logic [DW-1:0] nv_rdata,
  output logic          sys_rst,
  output logic [1:0]    rst_cause,
  output logic [DW-1:0] ctl_rdata
);
  localparam int HW  = $clog2(MIN_PULSE + 1);
  localparam int WCW = $clog2(WDOG_CYCLES);

  logic           por_busy, pin_low, wd_hit, wd_clear, ill_hit;
  logic [WCW-1:0] wd_count;
  logic [HW-1:0]  hold_q, hold_nxt;
  logic           rst_q;
  cause_e         cause_q, cause_src, cause_nxt;
  logic           evt, src_any;
  logic           unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DW-1:1];

  rsthub_por #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk(clk), .osc_ok(osc_ok), .por_busy(por_busy));

  rsthub_pin_qual #(.PIN_SAMPLES(PIN_SAMPLES)) u_pin (
    .clk(clk), .osc_ok(osc_ok), .pin_n(pin_n), .pin_low(pin_low));

  rsthub_wdog #(.WDOG_CYCLES(WDOG_CYCLES), .AW(AW), .WDOG_ADDR(WDOG_ADDR)) u_wdog (
    .clk(clk), .osc_ok(osc_ok), .in_rst(rst_q), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wbit0(bus_wdata[0]), .wd_hit(wd_hit),
    .wd_clear(wd_clear), .wd_count(wd_count));

  rsthub_addr_chk #(.AW(AW), .NUM_WIN(NUM_WIN), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_addr (
    .en(!rst_q), .bus_fetch(bus_fetch), .bus_addr(bus_addr), .ill_hit(ill_hit));

  assign evt     = pin_low | wd_hit | ill_hit;
  assign src_any = por_busy | evt;

  always_comb begin
    if (evt)              hold_nxt = HW'(MIN_PULSE);
    else if (hold_q != 0) hold_nxt = hold_q - 1'b1;
    else                  hold_nxt = '0;

    cause_src = pick_cause(por_busy, pin_low, wd_hit, ill_hit);
    cause_nxt = cause_q;
    if (src_any) begin
      if (!rst_q || (cause_src < cause_q)) cause_nxt = cause_src;
    end
  end

  always_ff @(posedge clk) begin
    if (!osc_ok) begin
      rst_q   <= 1'b1;
      hold_q  <= '0;
      cause_q <= CAUSE_POWER;
    end else begin
      rst_q   <= por_busy | (hold_nxt != 0);
      hold_q  <= hold_nxt;
      cause_q <= cause_nxt;
    end
  end

  assign sys_rst   = rst_q;
  assign rst_cause = cause_q;
  assign ctl_rdata = nv_rdata;
endmodule

// File: rtl/mcu_reset_hub_chk.sv
module mcu_reset_hub_chk
  import rsthub_pkg::*;
#(
  parameter int WCW = 15
) (
  input logic           clk,
  input logic           osc_ok,
  input logic           sys_rst,
  input logic [1:0]     rst_cause,
  input logic           por_busy,
  input logic           pin_low,
  input logic           wd_hit,
  input logic           wd_clear,
  input logic           ill_hit,
  input logic [WCW-1:0] wd_count
);
  logic seen_q;
  always_ff @(posedge clk) seen_q <= osc_ok;

  a_r1_por_holds: assert property (@(posedge clk) disable iff (!osc_ok)
    por_busy |=> (sys_rst && rst_cause == CAUSE_POWER));

  a_r3_pin_holds: assert property (@(posedge clk) disable iff (!osc_ok)
    pin_low |=> sys_rst);

  a_r4_wdog_held: assert property (@(posedge clk) disable iff (!osc_ok)
    sys_rst |=> (wd_count == '0));

  a_r5_wdog_clear: assert property (@(posedge clk) disable iff (!osc_ok)
    wd_clear |=> (wd_count == '0));

  a_r7_addr_reset: assert property (@(posedge clk) disable iff (!osc_ok)
    (ill_hit && !pin_low && !wd_hit && !por_busy) |=> (sys_rst && rst_cause == CAUSE_ADDR));

  a_r9_min_pulse: assert property (@(posedge clk) disable iff (!osc_ok)
    (seen_q && $rose(sys_rst)) |=> sys_rst);

  a_r10_cause_rank: assert property (@(posedge clk) disable iff (!osc_ok)
    (seen_q && sys_rst && $past(sys_rst)) |-> (rst_cause <= $past(rst_cause)));
endmodule

bind mcu_reset_hub mcu_reset_hub_chk #(.WCW(WCW)) u_chk (
  .clk(clk), .osc_ok(osc_ok), .sys_rst(sys_rst), .rst_cause(rst_cause),
  .por_busy(por_busy), .pin_low(pin_low), .wd_hit(wd_hit),
  .wd_clear(wd_clear), .ill_hit(ill_hit), .wd_count(wd_count));

// File: tb/mcu_reset_hub_tb.sv
module mcu_reset_hub_tb;
  localparam int POR  = 4064;
  localparam int WDOG = 512;
  localparam int MINP = 4;

  logic        clk = 1'b0;
  logic        osc_ok = 1'b0, pin_n = 1'b1, bus_wr = 1'b0, bus_fetch = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0, nv_rdata = '0;
  logic        sys_rst;
  logic [1:0]  rst_cause;
  logic [7:0]  ctl_rdata;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  mcu_reset_hub #(.WDOG_CYCLES(WDOG), .MIN_PULSE(MINP)) u_dut (
    .clk(clk), .osc_ok(osc_ok), .pin_n(pin_n), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_fetch(bus_fetch),
    .nv_rdata(nv_rdata), .sys_rst(sys_rst), .rst_cause(rst_cause),
    .ctl_rdata(ctl_rdata));

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_low(output int n);
    n = 0;
    while (sys_rst && n < 10000) begin tick(); n++; end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0; bus_addr = '0;
  endtask

  function automatic bit is_illegal(input int a);
    return !((a >= 'h090 && a <= 'h0FF) || (a >= 'h700 && a <= 'hEFF));
  endfunction

  task automatic probe(input int a, input bit fetch);
    int n;
    bus_write(12'hFF0, 8'h00);
    bus_addr = 12'(a); bus_fetch = fetch;
    tick();
    bus_fetch = 1'b0; bus_addr = '0;
    if (fetch) check($sformatf("R7 fetch at %03h", a), int'(sys_rst), int'(is_illegal(a)));
    else       check($sformatf("R8 data at %03h", a), int'(sys_rst), 0);
    if (sys_rst) begin
      check("R7 cause", int'(rst_cause), 3);
      wait_low(n);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n, hi;
    bit got;
    tick(); tick(); tick();
    check("R1 reset while osc off", int'(sys_rst), 1);
    check("R1 cause while osc off", int'(rst_cause), 0);
    for (int v = 0; v < 256; v += 51) begin
      nv_rdata = 8'(v); #1;
      check("R6 readback", int'(ctl_rdata), v);
    end

    // R1 exact power-on length
    osc_ok = 1'b1; hi = 0;
    for (int k = 0; k < POR + 50; k++) begin
      tick();
      if (sys_rst) hi++;
    end
    check("R1 power-on length", hi, POR);
    check("R1 cause after power-on", int'(rst_cause), 0);

    // R3 one-cycle glitch rejected
    pin_n = 1'b0; tick(); pin_n = 1'b1;
    got = 0;
    for (int k = 0; k < 6; k++) begin tick(); if (sys_rst) got = 1; end
    check("R3 one-cycle glitch ignored", int'(got), 0);

    // R3 two-cycle low accepted
    pin_n = 1'b0; tick(); tick(); pin_n = 1'b1;
    got = 0;
    for (int k = 0; k < 4; k++) begin tick(); if (sys_rst) got = 1; end
    check("R3 two-cycle low accepted", int'(got), 1);
    check("R3 pin cause", int'(rst_cause), 1);
    wait_low(n);

    // R3 / R9 sustained pin reset
    pin_n = 1'b0;
    repeat (6) tick();
    check("R3 reset while pin low", int'(sys_rst), 1);
    check("R3 cause pin", int'(rst_cause), 1);
    pin_n = 1'b1;
    wait_low(n);
    check("R9 pin release stretch in range", int'(n >= MINP && n <= MINP + 2), 1);

    // R4 watchdog expiry, exact cycle, R9 exact length
    repeat (WDOG - 1) tick();
    check("R4 no reset before expiry", int'(sys_rst), 0);
    tick();
    check("R4 reset at expiry", int'(sys_rst), 1);
    check("R4 cause watchdog", int'(rst_cause), 2);
    wait_low(n);
    check("R9 watchdog pulse length", n, MINP);

    // R5 ignored writes: bit0=1 and other address
    repeat (99) tick();
    bus_write(12'hFF0, 8'h01);
    bus_write(12'hFF1, 8'h00);
    repeat (WDOG - 102) tick();
    check("R5 ignored writes, still low", int'(sys_rst), 0);
    tick();
    check("R5 ignored writes, expiry unchanged", int'(sys_rst), 1);
    wait_low(n);

    // R5 servicing restarts period
    repeat (399) tick();
    bus_write(12'hFF0, 8'hFE);
    repeat (WDOG - 400) tick();
    check("R5 serviced, no reset at old expiry", int'(sys_rst), 0);
    repeat (399) tick();
    check("R5 serviced, low one before new expiry", int'(sys_rst), 0);
    tick();
    check("R5 serviced, new expiry", int'(sys_rst), 1);
    check("R4 cause after service", int'(rst_cause), 2);
    wait_low(n);

    // R7 / R8 address sweep
    for (int a = 0; a < 4096; a += 37) begin
      probe(a, 1'b1);
      if (is_illegal(a)) probe(a, 1'b0);
    end
    probe('h080, 1'b1); probe('h080, 1'b0);
    probe('h08F, 1'b1); probe('h090, 1'b1); probe('h0FF, 1'b1); probe('h100, 1'b1);
    probe('h6FF, 1'b1); probe('h700, 1'b1); probe('hEFF, 1'b1); probe('hF00, 1'b1);
    probe('hFF0, 1'b1); probe('hFFF, 1'b1); probe('hFFF, 1'b0);

    // R10 oscillator drop overrides pin cause
    pin_n = 1'b0;
    repeat (5) tick();
    check("R10 pin episode cause", int'(rst_cause), 1);
    osc_ok = 1'b0; tick();
    check("R10 power overrides", int'(rst_cause), 0);
    tick(); tick();

    // R2 pin low through end of power-on
    osc_ok = 1'b1;
    repeat (POR + 20) tick();
    check("R2 reset held by pin", int'(sys_rst), 1);
    check("R2 cause stays power", int'(rst_cause), 0);
    pin_n = 1'b1;
    wait_low(n);
    check("R2 release after pin high", int'(n >= MINP && n <= MINP + 2), 1);
    check("R10 cause kept after episode", int'(rst_cause), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule